// File: doc/BRIEF.md
# Transmit Serial Elastic Buffer

This block passes the transmit bit stream from the internal transmit logic to the serial data pin while the transmit clock pin is an input. In that mode an external transceiver owns the bit clock. The internal logic keeps running from its own divided reference clock. A 16-entry single-bit buffer between the two clocks absorbs small rate differences. Each clock domain keeps its own Gray-coded pointer, and the other domain sees that pointer through a two-stage synchronizer. When the two rates drift too far apart, the buffer runs empty or full, and the block raises an underflow or an overflow flag.

When the clock-direction input is 0, the clock pin is an output. The pin then carries the internal clock, the data goes straight to the data pin, and the buffer is left untouched.

The input is a valid/ready stream with one bit per transfer, on the internal clock. A bit is taken at a rising edge of `int_clk` when `s_valid` and `s_ready` are both high. `s_ready` depends only on the buffer state and never on `s_valid`. The producer is paced by a fixed bit rate and may not honour back-pressure. A bit that it presents while `s_ready` is low is dropped and counted as an overflow. The producer holds `tx_on_in` high for the whole frame and drops it after the last bit.

Top module: `txef_top`

## Requirements
- R1: With `clk_dir_in`=1 the buffer holds at most 16 bits. `s_ready` is low exactly while 16 accepted bits are waiting, so with the reading clock stopped exactly 16 bits are accepted.
- R2: With `clk_dir_in`=1, accepted bits leave on `txd_out` in acceptance order, one bit per rising edge of `ext_txc_in`, with no bit lost or repeated while the rates match.
- R3: Reading starts only when the buffer holds at least 8 bits, or when `tx_on_in` is low and the buffer is not empty (tail flush). With 7 bits held and `tx_on_in` high, nothing leaves.
- R4: While the reader is waiting, or the buffer is empty, `txd_out` is 0 in external-clock mode.
- R5: If the reader finds the buffer empty at a read edge while `tx_on_in` is high, `err_under` goes high in the internal domain. The reader then waits again under the R3 rule.
- R6: A bit offered with `s_valid`=1 while `s_ready`=0 in external-clock mode is dropped, and `err_over` goes high.
- R7: Both error flags are sticky. Each is cleared one `int_clk` edge after a one-cycle pulse on its own clear input. If a new error occurs in the same cycle as the clear, the flag stays set.
- R8: With `clk_dir_in`=0, `txd_out` equals `s_valid & s_data` combinationally, `s_ready` is 1, `txc_oe` is 1 and `txc_out` follows `int_clk`. The buffer is not written and no overflow is raised.
- R9: With `clk_dir_in`=1, `txc_oe` is 0 and `txc_out` is 0.
- R10: The write and read pointers are Gray coded, and each changes by at most one bit per edge of its own clock.
- R11: After reset both flags are 0, `txd_out` is 0 and the buffer is empty (`s_ready`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal divided reference clock (write side) |
| int_rst_n | input | 1 | Active-low asynchronous reset, both domains |
| ext_txc_in | input | 1 | Bit clock from the external transceiver (read side) |
| clk_dir_in | input | 1 | 1: clock pin is an input and the buffer is used; 0: clock pin is an output and the buffer is bypassed |
| tx_on_in | input | 1 | High while a frame is being sent |
| s_valid | input | 1 | Input bit valid |
| s_data | input | 1 | Input bit |
| s_ready | output | 1 | Buffer can take a bit |
| clr_under_in | input | 1 | Write-one pulse that clears `err_under` |
| clr_over_in | input | 1 | Write-one pulse that clears `err_over` |
| txd_out | output | 1 | Serial data to the pin |
| txc_out | output | 1 | Clock pin drive value |
| txc_oe | output | 1 | Clock pin output enable |
| err_under | output | 1 | Sticky underflow flag |
| err_over | output | 1 | Sticky overflow flag |

## Verification
The embedded properties check, on every cycle, the following:
- the fill bound as seen by the writer;
- that each pointer moves as Gray code;
- that the reader holds the line low while it waits;
- that reading starts only with half depth held or during a tail flush;
- that both flags stay sticky and clear on request.

Only the bench scenarios show the end-to-end facts. These are the bit order across the two clocks for frame lengths 1 to 20, the exact 16-bit capacity with the read clock stopped, the rate mismatches that cause overflow and underflow, and the bypass path.

// File: rtl/txef_pkg.sv
`timescale 1ns/1ps
package txef_pkg;

  typedef enum logic {RD_WAIT = 1'b0, RD_RUN = 1'b1} rd_state_e;

  function automatic logic [15:0] b2g(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] g2b(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/txef_sync.sv
`timescale 1ns/1ps
module txef_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/txef_wr.sv
`timescale 1ns/1ps
module txef_wr
  import txef_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             s_valid,
  input  logic             s_data,
  output logic             s_ready,
  input  logic [PW-1:0]    rgray_s,
  input  logic             clr_over,
  output logic [PW-1:0]    wgray,
  output logic [DEPTH-1:0] mem,
  output logic             err_over
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  logic [PW-1:0] wbin, rbin_s, wbin_nx, fill;
  logic          full, push, drop;

  assign rbin_s  = PW'(g2b(16'(rgray_s)));
  assign fill    = wbin - rbin_s;
  assign full    = (fill == FULL_LVL);
  assign s_ready = !en || !full;
  assign push    = en && s_valid && !full;
  assign drop    = en && s_valid && full;
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      mem   <= '0;
    end else if (push) begin
      mem[wbin[AW-1:0]] <= s_data;
      wbin  <= wbin_nx;
      wgray <= PW'(b2g(16'(wbin_nx)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_over <= 1'b0;
    else if (drop)     err_over <= 1'b1;
    else if (clr_over) err_over <= 1'b0;
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL); // R1
  AST_WPTR_GRAY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R10
  AST_OVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_over && !clr_over) |=> err_over); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s_valid && !s_ready) |=> err_over); // R6
endmodule

// File: rtl/txef_rd.sv
`timescale 1ns/1ps
module txef_rd
  import txef_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HALF  = DEPTH / 2,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             en_a,
  input  logic             on_a,
  input  logic [PW-1:0]    wgray_a,
  input  logic [DEPTH-1:0] mem,
  output logic [PW-1:0]    rgray,
  output logic             txd,
  output logic             under_tgl
);
  localparam logic [PW-1:0] HALF_LVL = PW'(HALF);

  logic          rst_n;
  logic [1:0]    rst_stg;
  logic [1:0]    ctl_s;
  logic [PW-1:0] wgray_s, wbin_s, rbin, rbin_nx, level;
  logic          en_s, on_s, start_ok;
  rd_state_e     state;

  // reset: asserted asynchronously, released on this clock
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_stg <= 2'b00;
    else         rst_stg <= {rst_stg[0], 1'b1};
  end
  assign rst_n = rst_stg[1];

  txef_sync #(.W(2)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({en_a, on_a}), .q(ctl_s));
  txef_sync #(.W(PW)) u_wptr_sync (
    .clk(clk), .rst_n(rst_n), .d(wgray_a), .q(wgray_s));

  assign en_s     = ctl_s[1];
  assign on_s     = ctl_s[0];
  assign wbin_s   = PW'(g2b(16'(wgray_s)));
  assign level    = wbin_s - rbin;
  assign rbin_nx  = rbin + PW'(1);
  assign start_ok = (level >= HALF_LVL) || (!on_s && level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RD_WAIT;
      rbin      <= '0;
      rgray     <= '0;
      txd       <= 1'b0;
      under_tgl <= 1'b0;
    end else begin
      txd <= 1'b0;
      if (!en_s) begin
        state <= RD_WAIT;
      end else if (state == RD_WAIT) begin
        if (start_ok) state <= RD_RUN;
      end else if (level != '0) begin
        txd   <= mem[rbin[AW-1:0]];
        rbin  <= rbin_nx;
        rgray <= PW'(b2g(16'(rbin_nx)));
      end else begin
        state <= RD_WAIT;
        if (on_s) under_tgl <= ~under_tgl;
      end
    end
  end

  AST_RPTR_GRAY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R10
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_WAIT) |=> (txd == 1'b0)); // R4
  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == RD_RUN) && ($past(state) == RD_WAIT)) |->
      $past((level >= HALF_LVL) || (!on_s && level != '0))); // R3
endmodule

// File: rtl/txef_top.sv
`timescale 1ns/1ps
module txef_top #(
  parameter int DEPTH = 16,
  parameter int HALF  = DEPTH / 2
) (
  input  logic int_clk,
  input  logic int_rst_n,
  input  logic ext_txc_in,
  input  logic clk_dir_in,
  input  logic tx_on_in,
  input  logic s_valid,
  input  logic s_data,
  output logic s_ready,
  input  logic clr_under_in,
  input  logic clr_over_in,
  output logic txd_out,
  output logic txc_out,
  output logic txc_oe,
  output logic err_under,
  output logic err_over
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]    wgray, rgray, rgray_s;
  logic [DEPTH-1:0] mem;
  logic             tx_on_q, rd_txd, under_tgl, under_tgl_s, under_tgl_q, under_evt;

  always_ff @(posedge int_clk or negedge int_rst_n) begin
    if (!int_rst_n) tx_on_q <= 1'b0;
    else            tx_on_q <= tx_on_in;
  end

  txef_sync #(.W(PW)) u_rptr_sync (
    .clk(int_clk), .rst_n(int_rst_n), .d(rgray), .q(rgray_s));

  txef_wr #(.DEPTH(DEPTH)) u_wr (
    .clk(int_clk), .rst_n(int_rst_n), .en(clk_dir_in),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .rgray_s(rgray_s), .clr_over(clr_over_in),
    .wgray(wgray), .mem(mem), .err_over(err_over));

  txef_rd #(.DEPTH(DEPTH), .HALF(HALF)) u_rd (
    .clk(ext_txc_in), .arst_n(int_rst_n), .en_a(clk_dir_in),
    .on_a(tx_on_q), .wgray_a(wgray), .mem(mem),
    .rgray(rgray), .txd(rd_txd), .under_tgl(under_tgl));

  txef_sync #(.W(1)) u_under_sync (
    .clk(int_clk), .rst_n(int_rst_n), .d(under_tgl), .q(under_tgl_s));

  always_ff @(posedge int_clk or negedge int_rst_n) begin
    if (!int_rst_n) under_tgl_q <= 1'b0;
    else            under_tgl_q <= under_tgl_s;
  end
  assign under_evt = under_tgl_s ^ under_tgl_q;

  always_ff @(posedge int_clk or negedge int_rst_n) begin
    if (!int_rst_n)        err_under <= 1'b0;
    else if (under_evt)    err_under <= 1'b1;
    else if (clr_under_in) err_under <= 1'b0;
  end

  assign txd_out = clk_dir_in ? rd_txd : (s_valid & s_data);
  assign txc_oe  = !clk_dir_in;
  assign txc_out = clk_dir_in ? 1'b0 : int_clk;

  AST_UNDER_HOLD: assert property (@(posedge int_clk) disable iff (!int_rst_n)
    (err_under && !clr_under_in) |=> err_under); // R7
  AST_UNDER_CLEAR: assert property (@(posedge int_clk) disable iff (!int_rst_n)
    (clr_under_in && !under_evt) |=> !err_under); // R7
  AST_OVER_CLEAR: assert property (@(posedge int_clk) disable iff (!int_rst_n)
    (clr_over_in && !(clk_dir_in && s_valid && !s_ready)) |=> !err_over); // R7
endmodule

// File: tb/txef_top_test.sv
`timescale 1ns/1ps
module txef_top_test;
  logic int_clk = 1'b0, int_rst_n = 1'b0, ext_txc = 1'b0;
  logic clk_dir = 1'b1, tx_on = 1'b0, s_valid = 1'b0, s_data = 1'b0;
  logic clr_under = 1'b0, clr_over = 1'b0;
  logic s_ready, txd_out, txc_out, txc_oe, err_under, err_over;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  ext_run = 1'b1;
  real ext_half = 2.5;
  bit  frm [64];
  bit  cap [512];
  int  cap_n = 0;
  bit  cap_en = 1'b0;

  txef_top uut (
    .int_clk(int_clk), .int_rst_n(int_rst_n), .ext_txc_in(ext_txc),
    .clk_dir_in(clk_dir), .tx_on_in(tx_on), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .clr_under_in(clr_under), .clr_over_in(clr_over),
    .txd_out(txd_out), .txc_out(txc_out), .txc_oe(txc_oe),
    .err_under(err_under), .err_over(err_over));

  always #2.5 int_clk = ~int_clk;

  initial begin
    #1.3;
    forever begin
      #(ext_half);
      if (ext_run || ext_txc) ext_txc = ~ext_txc;
    end
  end

  always @(negedge ext_txc) begin
    if (cap_en && cap_n < 512) begin
      cap[cap_n] = txd_out;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic make_frame(input int len, input int seed);
    for (int i = 0; i < 64; i++)
      frm[i] = (i == 0) ? 1'b1 : (i < len) ? 1'(((i * 7 + seed) * (seed | 1)) >> 3) : 1'b0;
  endtask

  task automatic send(input int from, input int to, input bit hold_on, output int acc);
    acc = 0;
    for (int i = from; i < to; i++) begin
      @(negedge int_clk);
      acc += int'(s_ready);
      s_valid = 1'b1;
      s_data  = frm[i];
      tx_on   = 1'b1;
    end
    @(negedge int_clk);
    s_valid = 1'b0;
    s_data  = 1'b0;
    tx_on   = hold_on;
  endtask

  task automatic cap_start();
    cap_n  = 0;
    cap_en = 1'b1;
  endtask

  function automatic int first_one();
    for (int i = 0; i < cap_n; i++) if (cap[i]) return i;
    return -1;
  endfunction

  // compares the captured stream with frm[0..n-1], then expects zeros
  task automatic cmp_stream(input int n, input string req);
    int f, bad;
    f = first_one();
    bad = 0;
    if (f < 0) begin
      chk(1'b0, req, -1, 0);
    end else begin
      for (int i = 0; i < n; i++)
        if (f + i >= cap_n || cap[f + i] != frm[i]) bad++;
      for (int i = f + n; i < cap_n; i++) if (cap[i]) bad++;
      chk(bad == 0, req, bad, 0);
    end
  endtask

  task automatic pulse_clr(input bit under);
    @(negedge int_clk);
    if (under) clr_under = 1'b1; else clr_over = 1'b1;
    @(negedge int_clk);
    clr_under = 1'b0;
    clr_over  = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int acc, ones;
    repeat (4) @(negedge int_clk);
    int_rst_n = 1'b1;
    repeat (6) @(negedge int_clk);

    // R11 reset state, R9 clock pin as input
    chk(txd_out == 0, "R11 txd after reset", txd_out, 0);
    chk(err_under == 0, "R11 err_under after reset", err_under, 0);
    chk(err_over == 0, "R11 err_over after reset", err_over, 0);
    chk(s_ready == 1, "R11 empty after reset", s_ready, 1);
    chk(txc_oe == 0, "R9 txc_oe in input mode", txc_oe, 0);
    chk(txc_out == 0, "R9 txc_out in input mode", txc_out, 0);

    // R2 R3 R4 matched rates, frame lengths 1..20
    for (int len = 1; len <= 20; len++) begin
      make_frame(len, len * 3 + 1);
      cap_start();
      send(0, len, 1'b0, acc);
      repeat (60) @(negedge int_clk);
      cap_en = 1'b0;
      cmp_stream(len, "R2 bit order matched rate");
      chk(acc == len, "R1 all bits accepted", acc, len);
      chk(!err_under && !err_over, "R5 no error at matched rate",
          int'({err_under, err_over}), 0);
    end

    // R3 seven bits held, no start; R5 underflow after the eighth
    make_frame(8, 11);
    cap_start();
    send(0, 7, 1'b1, acc);
    repeat (40) @(negedge int_clk);
    chk(first_one() < 0, "R3 no read below half depth", first_one(), -1);
    send(7, 8, 1'b1, acc);
    repeat (40) @(negedge int_clk);
    cap_en = 1'b0;
    cmp_stream(8, "R3 read starts at half depth");
    chk(err_under == 1, "R5 underflow while frame active", err_under, 1);
    tx_on = 1'b0;
    repeat (20) @(negedge int_clk);
    chk(err_under == 1, "R7 underflow flag sticky", err_under, 1);
    pulse_clr(1'b1);
    chk(err_under == 0, "R7 underflow clear", err_under, 0);

    // R1 R6 read clock stopped: exactly 16 taken, rest dropped
    ext_run = 1'b0;
    repeat (4) @(negedge int_clk);
    make_frame(20, 5);
    cap_start();
    send(0, 20, 1'b0, acc);
    chk(acc == 16, "R1 capacity with stopped read clock", acc, 16);
    chk(s_ready == 0, "R1 ready low when full", s_ready, 0);
    chk(err_over == 1, "R6 overflow on dropped bit", err_over, 1);
    ext_run = 1'b1;
    repeat (80) @(negedge int_clk);
    cap_en = 1'b0;
    cmp_stream(16, "R6 dropped bits absent from output");
    chk(err_over == 1, "R7 overflow flag sticky", err_over, 1);
    pulse_clr(1'b0);
    chk(err_over == 0, "R7 overflow clear", err_over, 0);

    // R6 slow external clock
    ext_half = 7.0;
    make_frame(60, 9);
    send(0, 60, 1'b0, acc);
    chk(err_over == 1, "R6 overflow at slow read clock", err_over, 1);
    chk(acc < 60, "R6 some bits refused", acc, 59);
    repeat (400) @(negedge int_clk);
    pulse_clr(1'b0);
    chk(err_over == 0, "R7 overflow cleared after slow run", err_over, 0);

    // R5 fast external clock
    ext_half = 1.5;
    make_frame(30, 13);
    send(0, 30, 1'b1, acc);
    repeat (20) @(negedge int_clk);
    chk(err_under == 1, "R5 underflow at fast read clock", err_under, 1);
    tx_on = 1'b0;
    repeat (20) @(negedge int_clk);
    pulse_clr(1'b1);
    chk(err_under == 0, "R7 underflow cleared after fast run", err_under, 0);
    ext_half = 2.5;
    repeat (40) @(negedge int_clk);

    // R8 bypass mode
    clk_dir = 1'b0;
    repeat (10) @(negedge int_clk);
    chk(txc_oe == 1, "R8 txc_oe in output mode", txc_oe, 1);
    @(posedge int_clk); #1;
    chk(txc_out == 1, "R8 txc_out high phase", txc_out, 1);
    @(negedge int_clk); #1;
    chk(txc_out == 0, "R8 txc_out low phase", txc_out, 0);
    make_frame(24, 17);
    for (int i = 0; i < 24; i++) begin
      @(negedge int_clk);
      s_valid = (i % 5 != 4);
      s_data  = frm[i] | (i == 3);
      tx_on   = 1'b1;
      #1;
      chk(txd_out == (s_valid & s_data), "R8 data passes straight",
          txd_out, int'(s_valid & s_data));
      chk(s_ready == 1, "R8 ready always high", s_ready, 1);
    end
    @(negedge int_clk);
    s_valid = 1'b0;
    tx_on   = 1'b0;
    chk(err_over == 0, "R8 no overflow in bypass", err_over, 0);
    clk_dir = 1'b1;
    cap_start();
    repeat (60) @(negedge int_clk);
    cap_en = 1'b0;
    ones = 0;
    for (int i = 0; i < cap_n; i++) ones += int'(cap[i]);
    chk(ones == 0, "R8 buffer untouched in bypass", ones, 0);
    chk(txd_out == 0, "R4 idle low after bypass", txd_out, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule